// File: doc/BRIEF.md
# LCD Row Timing Generator

This block produces the row-scan timing for the common (row) side of a dot-matrix LCD. As the timing master it halves the system clock to form the line transfer clock, marks the first line of every frame, and drives the display-enable output. As a slave it gives up its timing pins. The clock, marker and display-enable arriving from a master device then pass straight to the internal users.

A frame-size input selects a 120-line or a 240-line scan. After reset the display-enable output stays low until four frame markers have gone by, so that no garbage is shown while the panel settles. A display-off input can blank the panel at any time while the block is master. Single-cycle line and frame strobes, taken from the resolved line clock and marker, are provided for neighbouring logic such as the polarity-inversion generator.

Top module: `lcd_row_timer`

## Requirements
- R1: In master mode (`master_i`=1) the line clock `cl1_o` toggles on every system clock edge, giving a period of two clocks and 50% duty. The first edge after reset release drives it high.
- R2: The line counter advances on each falling edge of the master line clock and wraps to line 0 after line 119 when `duty_i`=0, or after line 239 when `duty_i`=1. The marker therefore repeats every 240 or 480 system clocks.
- R3: In master mode `flm_o` is high for exactly one line-clock period (two system clocks), during line 0 of each frame, and line 0 is the first line after reset release.
- R4: In slave mode (`master_i`=0), `cl1_o`, `flm_o` and `doc_o` equal `cl1_i`, `flm_i` and `doc_i`. `dispoff_n_i` has no effect on `doc_o`. `pin_oe_o` is 1 in master mode and 0 in slave mode.
- R5: Reset is asynchronous and active low. While it is low the counters are cleared, `cl1_o` is 0, `flm_o` is 1 (line 0) and `doc_o` is 0 in master mode.
- R6: After reset release in master mode, `doc_o` stays 0 until four frame strobes have occurred. For the default sizes this is 2*L*3+3 system clock edges after release, where L is the frame length.
- R7: In master mode `doc_o` is 0 whenever `dispoff_n_i` is 0, in the same cycle. Once the hold has ended, `doc_o` follows `dispoff_n_i`.
- R8: `line_stb_o` is a one-cycle pulse in the cycle after each falling edge of the resolved line clock, as seen at a system clock edge. This holds in both modes.
- R9: `frame_stb_o` pulses together with `line_stb_o` only when the marker was high at the clock edge that observed that falling edge.
- R10: The post-reset hold count saturates at four, so `doc_o` stays enabled over any number of later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = timing master, 0 = slave |
| duty_i | input | 1 | Frame size: 0 = 120 lines, 1 = 240 lines |
| dispoff_n_i | input | 1 | Active-low display-off request (master only) |
| cl1_i | input | 1 | Line clock from the pin in slave mode |
| flm_i | input | 1 | First-line marker from the pin in slave mode |
| doc_i | input | 1 | Display-enable from the pin in slave mode |
| cl1_o | output | 1 | Resolved line clock |
| flm_o | output | 1 | Resolved first-line marker |
| doc_o | output | 1 | Resolved display-enable (1 = display on) |
| pin_oe_o | output | 1 | Output enable for the three timing pins |
| line_stb_o | output | 1 | One-cycle strobe per line |
| frame_stb_o | output | 1 | One-cycle strobe per frame |

## Verification
Several properties are checked on every cycle: the line clock toggles each cycle in master mode, the counter steps and wraps at the limit set by the frame size, line strobes last one cycle, frame strobes follow a high marker, and the enable output stays low during the hold and under display-off. The hold count is also checked to stay saturated. The exact marker positions, the clock edge at which the hold ends for each frame size, slave pass-through with a randomly toggling display-off input, and recovery from a reset in mid-frame can only be shown by the bench's scenarios, which compare each output against closed-form expectations.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;
endpackage

// File: rtl/lrt_scan_counter.sv
module lrt_scan_counter #(
  parameter int unsigned LINES_SHORT = 120,
  parameter int unsigned LINES_LONG  = 240,
  parameter int unsigned LW          = $clog2(LINES_LONG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          duty,
  output logic          cl1,
  output logic          first_line,
  output logic [LW-1:0] line_cnt
);
  localparam logic [LW-1:0] LAST_SHORT = LW'(LINES_SHORT - 1);
  localparam logic [LW-1:0] LAST_LONG  = LW'(LINES_LONG - 1);

  logic          ph_q, ph_d;
  logic [LW-1:0] line_q, line_d;
  logic [LW-1:0] last_line;

  always_comb begin
    last_line = duty ? LAST_LONG : LAST_SHORT;
    ph_d      = ph_q;
    line_d    = line_q;
    if (en) begin
      ph_d = ~ph_q;
      if (ph_q) begin
        line_d = (line_q >= last_line) ? '0 : line_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      line_q <= '0;
    end else begin
      ph_q   <= ph_d;
      line_q <= line_d;
    end
  end

  assign cl1        = ph_q;
  assign first_line = (line_q == '0);
  assign line_cnt   = line_q;
endmodule

// File: rtl/lrt_strobe_gen.sv
module lrt_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic cl1,
  input  logic flm,
  output logic line_stb,
  output logic frame_stb
);
  logic cl1_q, flm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl1_q <= 1'b0;
      flm_q <= 1'b0;
    end else begin
      cl1_q <= cl1;
      flm_q <= flm;
    end
  end

  always_comb begin
    line_stb  = cl1_q & ~cl1;
    frame_stb = line_stb & flm_q;
  end
endmodule

// File: rtl/lrt_doc_ctrl.sv
module lrt_doc_ctrl #(
  parameter int unsigned HOLD_FRAMES = 4,
  parameter int unsigned HW          = $clog2(HOLD_FRAMES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic          dispoff_n,
  output logic          doc,
  output logic [HW-1:0] hold_cnt
);
  localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_FRAMES);

  logic [HW-1:0] hold_q, hold_d;
  logic          hold_done;

  always_comb begin
    hold_done = (hold_q == HOLD_MAX);
    hold_d    = hold_q;
    if (frame_stb && !hold_done) begin
      hold_d = hold_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign doc      = hold_done & dispoff_n;
  assign hold_cnt = hold_q;
endmodule

// File: rtl/lcd_row_timer.sv
module lcd_row_timer #(
  parameter int unsigned LINES_SHORT = 120,
  parameter int unsigned LINES_LONG  = 240,
  parameter int unsigned HOLD_FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_i,
  input  logic duty_i,
  input  logic dispoff_n_i,
  input  logic cl1_i,
  input  logic flm_i,
  input  logic doc_i,
  output logic cl1_o,
  output logic flm_o,
  output logic doc_o,
  output logic pin_oe_o,
  output logic line_stb_o,
  output logic frame_stb_o
);
  import lrt_pkg::*;

  localparam int unsigned LW = $clog2(LINES_LONG);
  localparam int unsigned HW = $clog2(HOLD_FRAMES + 1);

  role_e         role;
  logic          cl1_gen, flm_gen, doc_gen;
  logic [LW-1:0] line_cnt;
  logic [HW-1:0] hold_cnt;

  assign role = role_e'(master_i);

  lrt_scan_counter #(
    .LINES_SHORT(LINES_SHORT),
    .LINES_LONG (LINES_LONG),
    .LW         (LW)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (role == ROLE_MASTER),
    .duty      (duty_i),
    .cl1       (cl1_gen),
    .first_line(flm_gen),
    .line_cnt  (line_cnt)
  );

  always_comb begin
    if (role == ROLE_MASTER) begin
      cl1_o    = cl1_gen;
      flm_o    = flm_gen;
      doc_o    = doc_gen;
      pin_oe_o = 1'b1;
    end else begin
      cl1_o    = cl1_i;
      flm_o    = flm_i;
      doc_o    = doc_i;
      pin_oe_o = 1'b0;
    end
  end

  lrt_strobe_gen u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .cl1      (cl1_o),
    .flm      (flm_o),
    .line_stb (line_stb_o),
    .frame_stb(frame_stb_o)
  );

  lrt_doc_ctrl #(
    .HOLD_FRAMES(HOLD_FRAMES),
    .HW         (HW)
  ) u_doc (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_stb(frame_stb_o),
    .dispoff_n(dispoff_n_i),
    .doc      (doc_gen),
    .hold_cnt (hold_cnt)
  );
endmodule

// File: rtl/lrt_checker.sv
module lrt_checker #(
  parameter int unsigned LINES_SHORT = 120,
  parameter int unsigned LINES_LONG  = 240,
  parameter int unsigned HOLD_FRAMES = 4,
  parameter int unsigned LW          = $clog2(LINES_LONG),
  parameter int unsigned HW          = $clog2(HOLD_FRAMES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_i,
  input logic          duty_i,
  input logic          dispoff_n_i,
  input logic          cl1_o,
  input logic          flm_o,
  input logic          doc_o,
  input logic          line_stb_o,
  input logic          frame_stb_o,
  input logic          cl1_gen,
  input logic [LW-1:0] line_cnt,
  input logic [HW-1:0] hold_cnt
);
  logic [LW-1:0] last_line;
  assign last_line = duty_i ? LW'(LINES_LONG - 1) : LW'(LINES_SHORT - 1);

  AST_CL1_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    master_i |=> (cl1_gen != $past(cl1_gen)));  // R1

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && cl1_gen && line_cnt >= last_line) |=> (line_cnt == '0));  // R2

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && cl1_gen && line_cnt < last_line) |=> (line_cnt == $past(line_cnt) + 1'b1));  // R2

  AST_LINE_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb_o |=> !line_stb_o);  // R8

  AST_FRAME_AFTER_FLM: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_o |-> $past(flm_o));  // R9

  AST_DOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && hold_cnt != HW'(HOLD_FRAMES)) |-> !doc_o);  // R6

  AST_DISPOFF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && !dispoff_n_i) |-> !doc_o);  // R7

  AST_HOLD_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt == HW'(HOLD_FRAMES)) |=> (hold_cnt == HW'(HOLD_FRAMES)));  // R10

  always @(posedge clk) begin
    if (!rst_n && master_i) begin
      AST_RESET_QUIET: assert (!doc_o && !cl1_o && flm_o);  // R5
    end
  end
endmodule

bind lcd_row_timer lrt_checker #(
  .LINES_SHORT(LINES_SHORT),
  .LINES_LONG (LINES_LONG),
  .HOLD_FRAMES(HOLD_FRAMES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .master_i   (master_i),
  .duty_i     (duty_i),
  .dispoff_n_i(dispoff_n_i),
  .cl1_o      (cl1_o),
  .flm_o      (flm_o),
  .doc_o      (doc_o),
  .line_stb_o (line_stb_o),
  .frame_stb_o(frame_stb_o),
  .cl1_gen    (cl1_gen),
  .line_cnt   (line_cnt),
  .hold_cnt   (hold_cnt)
);

// File: tb/lcd_row_timer_test.sv
module lcd_row_timer_test;
  localparam int HOLD = 4;

  logic clk, rst_n, master_i, duty_i, dispoff_n_i, cl1_i, flm_i, doc_i;
  logic cl1_o, flm_o, doc_o, pin_oe_o, line_stb_o, frame_stb_o;
  int   n_checks, n_fails;

  lcd_row_timer uut (
    .clk(clk), .rst_n(rst_n), .master_i(master_i), .duty_i(duty_i),
    .dispoff_n_i(dispoff_n_i), .cl1_i(cl1_i), .flm_i(flm_i), .doc_i(doc_i),
    .cl1_o(cl1_o), .flm_o(flm_o), .doc_o(doc_o), .pin_oe_o(pin_oe_o),
    .line_stb_o(line_stb_o), .frame_stb_o(frame_stb_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected values after n clock edges since reset release, frame length L
  function automatic bit e_cl1(int n);
    return bit'(n % 2);
  endfunction
  function automatic bit e_flm(int n, int L);
    return ((n / 2) % L) == 0;
  endfunction
  function automatic bit e_lstb(int n);
    return (n >= 2) && (n % 2 == 0);
  endfunction
  function automatic bit e_fstb(int n, int L);
    return e_lstb(n) && (((n - 1) / 2) % L == 0);
  endfunction
  function automatic bit e_hold_done(int n, int L);
    return n >= 2 * L * (HOLD - 1) + 3;
  endfunction

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_master(input int n, input int L, input bit doff_n);
    chk(cl1_o, e_cl1(n), "R1", "cl1_o");
    chk(flm_o, e_flm(n, L), (L == 240) ? "R2" : "R3", "flm_o");
    chk(line_stb_o, e_lstb(n), "R8", "line_stb_o");
    chk(frame_stb_o, e_fstb(n, L), "R9", "frame_stb_o");
    chk(doc_o, e_hold_done(n, L) && doff_n, e_hold_done(n, L) ? "R7" : "R6", "doc_o");
    chk(pin_oe_o, 1'b1, "R4", "pin_oe_o master");
  endtask

  task automatic run_master(input bit duty, input int cycles, input int off_rate);
    int L;
    L = duty ? 240 : 120;
    master_i = 1'b1;
    duty_i = duty;
    dispoff_n_i = 1'b1;
    do_reset();
    #1;
    chk(cl1_o, 1'b0, "R5", "cl1_o after release");
    chk(flm_o, 1'b1, "R5", "flm_o after release");
    chk(doc_o, 1'b0, "R5", "doc_o after release");
    for (int n = 1; n <= cycles; n++) begin
      @(negedge clk);
      check_master(n, L, dispoff_n_i);
      if (off_rate > 0) dispoff_n_i = ($urandom % off_rate) != 0;
    end
    dispoff_n_i = 1'b1;
  endtask

  task automatic run_slave(input int cycles);
    bit pc, pf;
    master_i = 1'b0;
    cl1_i = 1'b0; flm_i = 1'b0; doc_i = 1'b0;
    do_reset();
    pc = 1'b0; pf = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      cl1_i = bit'($urandom % 2);
      flm_i = bit'($urandom % 2);
      doc_i = bit'($urandom % 2);
      dispoff_n_i = bit'($urandom % 2);
      #1;
      chk(cl1_o, cl1_i, "R4", "cl1_o slave");
      chk(flm_o, flm_i, "R4", "flm_o slave");
      chk(doc_o, doc_i, "R4", "doc_o slave ignores dispoff");
      chk(pin_oe_o, 1'b0, "R4", "pin_oe_o slave");
      chk(line_stb_o, pc & ~cl1_i, "R8", "line_stb_o slave");
      chk(frame_stb_o, pc & ~cl1_i & pf, "R9", "frame_stb_o slave");
      pc = cl1_i; pf = flm_i;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    n_checks = 0; n_fails = 0;
    rst_n = 1'b0; master_i = 1'b1; duty_i = 1'b0; dispoff_n_i = 1'b1;
    cl1_i = 1'b0; flm_i = 1'b0; doc_i = 1'b0;
    @(negedge clk);
    // R5: state held in reset
    chk(doc_o, 1'b0, "R5", "doc_o in reset");
    chk(cl1_o, 1'b0, "R5", "cl1_o in reset");
    chk(flm_o, 1'b1, "R5", "flm_o in reset");
    chk(line_stb_o, 1'b0, "R5", "line_stb_o in reset");
    // R3/R6/R10: 120-line frames, no display-off, run well past the hold
    run_master(1'b0, 1800, 0);
    // R2/R7: 240-line frames with random display-off pulses
    run_master(1'b1, 3200, 8);
    // R7: 120-line frames with frequent display-off
    run_master(1'b0, 1000, 3);
    // R5: asynchronous reset in mid-frame
    run_master(1'b1, 300, 0);
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk(cl1_o, 1'b0, "R5", "cl1_o async reset");
    chk(flm_o, 1'b1, "R5", "flm_o async reset");
    chk(doc_o, 1'b0, "R5", "doc_o async reset");
    chk(line_stb_o, 1'b0, "R5", "line_stb_o async reset");
    // R4/R8/R9: slave pass-through and strobes
    run_slave(600);
    // back to master after slave to confirm restart
    run_master(1'b0, 800, 0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule